// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This unit performs four small multiplies in parallel on a pair of 64-bit operands. Operand B always supplies signed 16-bit multiplicands. Operand A supplies 8-bit multipliers, which are signed or unsigned depending on the mode. Each product is widened to 32 bits and rounded by one fixed rule. A narrow mode keeps product bits [23:8] of each lane as a 16-bit result. A widening mode keeps the whole rounded 32-bit product of lanes 0 and 1.

A 9-bit mode code picks how bytes of A pair with lanes of B:
- lane to byte (standard);
- one lane of B broadcast to all four products;
- the signed high byte of each A lane;
- the unsigned low byte of each A lane;
- widening variants of the last two.

Operands are presented with `in_valid`. The result appears one cycle later with `out_valid`. A mode code that is not recognised returns zero and raises `out_illegal`.

Top module: `pmul8x16_unit`

## Requirements
- R1: Mode 9'h031: 16-bit result lane r (bits [16r+15:16r]) is the rounded product of signed B lane r (bits [16r+15:16r]) and unsigned A byte r (bits [8r+7:8r]), for r = 0..3.
- R2: Rounding: the product is sign-extended to 32 bits. If its low byte exceeds 0x7F (bit 7 set), 0x100 is added. A narrow result is bits [23:8] of the rounded value.
- R3: Mode 9'h033 multiplies B lane 0 by each unsigned A byte r (r = 0..3). Mode 9'h035 does the same with B lane 1.
- R4: Mode 9'h036: result lane r is signed B lane r times the high byte of A lane r (bits [16r+15:16r+8]), taken as signed.
- R5: Mode 9'h037: result lane r is signed B lane r times the low byte of A lane r (bits [16r+7:16r]), taken as unsigned.
- R6: Modes 9'h038 (signed high byte, as R4) and 9'h039 (unsigned low byte, as R5) compute only lanes 0 and 1. Each full rounded 32-bit value is placed at bits [32r+31:32r]. Lanes 2 and 3 of A and B have no effect.
- R7: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result and flag belonging to that input are presented with it.
- R8: While `in_valid` is low, `out_data` keeps its last value.
- R9: Any other mode code gives `out_data` = 0 with `out_illegal` high in the result cycle. A recognised mode gives `out_illegal` low. `out_illegal` is never high without `out_valid`.
- R10: During and after reset, `out_valid`, `out_illegal` and `out_data` are zero until the first accepted input.
- R11: In every recognised mode, B equal to zero gives a zero result and no rounding increment in any lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| in_mode | input | 9 | Lane-pairing mode code |
| in_a | input | 64 | 8-bit multiplier source |
| in_b | input | 64 | Signed 16-bit multiplicand source |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Rounded partitioned result |
| out_illegal | output | 1 | Mode code of the returned result was not recognised |

## Verification
Some properties hold on every cycle, and the assertions check these:
- the valid strobe follows the input one cycle later;
- the result holds while idle;
- a bad mode gives a zeroed, flagged result, and a good mode gives a clear flag;
- a zero multiplicand yields zero with no lane rounding.

The lane arithmetic needs the bench's scenarios. These cover:
- which byte of A meets which lane of B in each mode;
- the sign treatment of the high byte;
- the exact rounding boundary at 0x7F/0x80 for positive and negative products;
- the widening mode ignoring lanes 2 and 3.

Expected results come from a separate integer model and from hand-worked values.

// File: rtl/pmul_pkg.sv
`timescale 1ns/1ps
package pmul_pkg;

  localparam int unsigned LANE_W    = 16;
  localparam int unsigned FAC_W     = 8;
  localparam int unsigned N_LANES   = 4;
  localparam int unsigned ACC_W     = 32;
  localparam int unsigned MODE_W    = 9;
  localparam int unsigned RND_SHIFT = 8;

  typedef enum logic [MODE_W-1:0] {
    MD_STD = 9'h031,
    MD_BC0 = 9'h033,
    MD_BC1 = 9'h035,
    MD_SU  = 9'h036,
    MD_UL  = 9'h037,
    MD_WSU = 9'h038,
    MD_WUL = 9'h039
  } pmul_mode_e;

  // Signed 16 x signed 9 product, sign-extended to the accumulator width.
  function automatic logic [ACC_W-1:0] lane_product(
    input logic signed [LANE_W-1:0] w,
    input logic signed [FAC_W:0]    f
  );
    logic signed [LANE_W+FAC_W:0] p;
    p = w * f;
    return {{(ACC_W-LANE_W-FAC_W-1){p[LANE_W+FAC_W]}}, p};
  endfunction

  // Rounding fires when the discarded byte is at or above one half.
  function automatic logic round_hit(input logic [ACC_W-1:0] p);
    return p[RND_SHIFT-1];
  endfunction

  function automatic logic [ACC_W-1:0] round_apply(input logic [ACC_W-1:0] p);
    logic [ACC_W-1:0] inc;
    inc = round_hit(p) ? (ACC_W'(1) << RND_SHIFT) : '0;
    return p + inc;
  endfunction

endpackage

// File: rtl/pmul_opsel.sv
`timescale 1ns/1ps
module pmul_opsel
  import pmul_pkg::*;
#(
  parameter int unsigned LANES = N_LANES,
  parameter int unsigned LW    = LANE_W,
  parameter int unsigned FW    = FAC_W,
  parameter int unsigned MW    = MODE_W,
  parameter int unsigned WL    = 2
) (
  input  logic [LANES*LW-1:0]        in_a,
  input  logic [LANES*LW-1:0]        in_b,
  input  logic [MW-1:0]              in_mode,
  output logic [LANES-1:0][LW-1:0]   lane_w,
  output logic [LANES-1:0][FW:0]     lane_f,
  output logic                       mode_known,
  output logic                       mode_wide
);

  always_comb begin
    mode_known = 1'b0;
    mode_wide  = 1'b0;
    case (in_mode)
      MD_STD, MD_BC0, MD_BC1, MD_SU, MD_UL: mode_known = 1'b1;
      MD_WSU, MD_WUL: begin
        mode_known = 1'b1;
        mode_wide  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    logic [LW-1:0] b_own;
    logic [FW-1:0] a_byte, a_hi, a_lo;
    logic [LW-1:0] sel_w;
    logic [FW:0]   sel_f;

    assign b_own  = in_b[r*LW +: LW];
    assign a_byte = in_a[r*FW +: FW];
    assign a_hi   = in_a[r*LW+FW +: FW];
    assign a_lo   = in_a[r*LW +: FW];

    always_comb begin
      sel_w = '0;
      sel_f = '0;
      case (in_mode)
        MD_STD: begin
          sel_w = b_own;
          sel_f = {1'b0, a_byte};
        end
        MD_BC0: begin
          sel_w = in_b[0 +: LW];
          sel_f = {1'b0, a_byte};
        end
        MD_BC1: begin
          sel_w = in_b[LW +: LW];
          sel_f = {1'b0, a_byte};
        end
        MD_SU: begin
          sel_w = b_own;
          sel_f = {a_hi[FW-1], a_hi};
        end
        MD_UL: begin
          sel_w = b_own;
          sel_f = {1'b0, a_lo};
        end
        MD_WSU: begin
          if (r < WL) begin
            sel_w = b_own;
            sel_f = {a_hi[FW-1], a_hi};
          end
        end
        MD_WUL: begin
          if (r < WL) begin
            sel_w = b_own;
            sel_f = {1'b0, a_lo};
          end
        end
        default: ;
      endcase
    end

    assign lane_w[r] = sel_w;
    assign lane_f[r] = sel_f;
  end

endmodule

// File: rtl/pmul_lane.sv
`timescale 1ns/1ps
module pmul_lane
  import pmul_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  parameter int unsigned FW = FAC_W,
  parameter int unsigned AW = ACC_W
) (
  input  logic [LW-1:0] w,
  input  logic [FW:0]   f,
  output logic [AW-1:0] rnd,
  output logic          rnd_up
);

  logic [AW-1:0] prod;

  assign prod   = lane_product(w, f);
  assign rnd_up = round_hit(prod);
  assign rnd    = round_apply(prod);

endmodule

// File: rtl/pmul_pack.sv
`timescale 1ns/1ps
module pmul_pack
  import pmul_pkg::*;
#(
  parameter int unsigned LANES = N_LANES,
  parameter int unsigned LW    = LANE_W,
  parameter int unsigned AW    = ACC_W,
  parameter int unsigned SH    = RND_SHIFT,
  parameter int unsigned WL    = 2
) (
  input  logic [LANES-1:0][AW-1:0] lane_rnd,
  input  logic                     mode_known,
  input  logic                     mode_wide,
  output logic [LANES*LW-1:0]      res
);

  logic [LANES*LW-1:0] narrow_v;
  logic [LANES*LW-1:0] wide_v;

  for (genvar r = 0; r < LANES; r++) begin : g_nar
    assign narrow_v[r*LW +: LW] = lane_rnd[r][SH +: LW];
  end

  for (genvar k = 0; k < WL; k++) begin : g_wide
    assign wide_v[k*AW +: AW] = lane_rnd[k];
  end

  if (WL*AW < LANES*LW) begin : g_wide_pad
    assign wide_v[LANES*LW-1:WL*AW] = '0;
  end

  assign res = !mode_known ? '0 : (mode_wide ? wide_v : narrow_v);

endmodule

// File: rtl/pmul8x16_unit.sv
`timescale 1ns/1ps
module pmul8x16_unit
  import pmul_pkg::*;
#(
  parameter int unsigned LANES = N_LANES,
  parameter int unsigned LW    = LANE_W,
  parameter int unsigned FW    = FAC_W,
  parameter int unsigned AW    = ACC_W,
  parameter int unsigned MW    = MODE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [MW-1:0]         in_mode,
  input  logic [LANES*LW-1:0]   in_a,
  input  logic [LANES*LW-1:0]   in_b,
  output logic                  out_valid,
  output logic [LANES*LW-1:0]   out_data,
  output logic                  out_illegal
);

  localparam int unsigned DATA_W = LANES * LW;
  localparam int unsigned WL     = DATA_W / AW;

  logic [LANES-1:0][LW-1:0] lane_w;
  logic [LANES-1:0][FW:0]   lane_f;
  logic [LANES-1:0][AW-1:0] lane_rnd;
  logic [LANES-1:0]         round_evt;
  logic                     known_mode;
  logic                     wide_mode;
  logic [DATA_W-1:0]        next_data;

  pmul_opsel #(.LANES(LANES), .LW(LW), .FW(FW), .MW(MW), .WL(WL)) u_sel (
    .in_a       (in_a),
    .in_b       (in_b),
    .in_mode    (in_mode),
    .lane_w     (lane_w),
    .lane_f     (lane_f),
    .mode_known (known_mode),
    .mode_wide  (wide_mode)
  );

  for (genvar r = 0; r < LANES; r++) begin : g_mul
    pmul_lane #(.LW(LW), .FW(FW), .AW(AW)) u_lane (
      .w      (lane_w[r]),
      .f      (lane_f[r]),
      .rnd    (lane_rnd[r]),
      .rnd_up (round_evt[r])
    );
  end

  pmul_pack #(.LANES(LANES), .LW(LW), .AW(AW), .SH(RND_SHIFT), .WL(WL)) u_pack (
    .lane_rnd   (lane_rnd),
    .mode_known (known_mode),
    .mode_wide  (wide_mode),
    .res        (next_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & ~known_mode;
      if (in_valid) begin
        out_data <= next_data;
      end
    end
  end

endmodule

// File: rtl/pmul8x16_chk.sv
`timescale 1ns/1ps
module pmul8x16_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANES  = 4,
  parameter int unsigned MW     = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal,
  input logic              known_mode,
  input logic [LANES-1:0]  round_evt
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data))); // R8

  AST_BAD_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !known_mode) |=> (out_illegal && out_data == '0)); // R9

  AST_GOOD_MODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && known_mode) |=> !out_illegal); // R9

  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid); // R9

  AST_ZERO_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && known_mode && in_b == '0) |=> out_data == '0); // R11

  AST_NO_ROUND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_b == '0) |-> round_evt == '0); // R2

endmodule

bind pmul8x16_unit pmul8x16_chk #(.DATA_W(DATA_W), .LANES(LANES), .MW(MW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal),
  .known_mode  (known_mode),
  .round_evt   (round_evt)
);

// File: tb/tb_pmul8x16_unit.sv
`timescale 1ns/1ps
module tb_pmul8x16_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  in_mode = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pmul8x16_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data),
    .out_illegal(out_illegal)
  );

  localparam int NV = 10;
  localparam logic [136:0] VEC [NV] = '{
    {9'h031, 64'h0102_0304_0506_0708, 64'h1111_2222_3333_4444},
    {9'h031, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_7FFF_FFFF_0001},
    {9'h033, 64'h0000_0000_7F80_01FF, 64'h0000_0000_0000_F00F},
    {9'h035, 64'h0000_0000_1020_3040, 64'h0000_0000_ABCD_1234},
    {9'h036, 64'h80FF_7F01_FF80_0102, 64'h1234_8001_7FFF_FFFE},
    {9'h037, 64'h00FF_1180_22AA_33CC, 64'h8000_4000_C000_0101},
    {9'h038, 64'h1234_5678_8081_7F7F, 64'hDEAD_BEEF_8000_7FFF},
    {9'h039, 64'h1234_5678_80FF_017F, 64'hDEAD_BEEF_FFFF_00FF},
    {9'h031, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
    {9'h037, 64'h8080_8080_8080_8080, 64'h0000_0000_0000_0000}
  };

  // Independent integer model: returns {illegal, data}.
  function automatic logic [64:0] model(input logic [8:0] m, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] res;
    longint p, bw, fa;
    bit wide;
    res  = '0;
    wide = (m == 9'h038) || (m == 9'h039);
    if (!(m inside {9'h031, 9'h033, 9'h035, 9'h036, 9'h037, 9'h038, 9'h039}))
      return {1'b1, 64'h0};
    for (int r = 0; r < 4; r++) begin
      if (m == 9'h033)      bw = longint'($signed(b[15:0]));
      else if (m == 9'h035) bw = longint'($signed(b[31:16]));
      else                  bw = longint'($signed(b[16*r +: 16]));
      case (m)
        9'h036, 9'h038: fa = longint'($signed(a[16*r+8 +: 8]));
        9'h037, 9'h039: fa = longint'(a[16*r +: 8]);
        default:        fa = longint'(a[8*r +: 8]);
      endcase
      p = bw * fa;
      if ((p & 255) > 127) p = p + 256;
      if (wide) begin
        if (r < 2) res[32*r +: 32] = p[31:0];
      end else begin
        res[16*r +: 16] = p[23:8];
      end
    end
    return {1'b0, res};
  endfunction

  function automatic string req_of(input logic [8:0] m);
    case (m)
      9'h031:         return "R1";
      9'h033, 9'h035: return "R3";
      9'h036:         return "R4";
      9'h037:         return "R5";
      default:        return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Present one operation, then sample at the following falling edge.
  task automatic run_op(input logic [8:0] m, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [63:0] held;
    logic [64:0] e;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid", {63'h0, out_valid}, 64'h0);
    chk("R10 out_data", out_data, 64'h0);
    chk("R10 out_illegal", {63'h0, out_illegal}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after release", {63'h0, out_valid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][136:128], VEC[i][127:64], VEC[i][63:0]);
      e = model(VEC[i][136:128], VEC[i][127:64], VEC[i][63:0]);
      chk({req_of(VEC[i][136:128]), " table data"}, out_data, e[63:0]);
      chk("R7 table valid", {63'h0, out_valid}, 64'h1);
    end

    // R1 hand-worked: 0x100*0x80, 1*1, -32768*255, lane3 by zero
    run_op(9'h031, 64'h0000_0000_00FF_0180, 64'h1234_8000_0001_0100);
    chk("R1 standard", out_data, 64'h0000_8080_0000_0080);

    // R2 boundary: 1*0x80 rounds up, 1*0x7F not, -1*0x80 rounds to 0, -1*0x81 not
    run_op(9'h031, 64'h0000_0000_8180_7F80, 64'hFFFF_FFFF_0001_0001);
    chk("R2 rounding edge", out_data, 64'hFFFF_0000_0000_0001);

    // R3 broadcast of B lane 1 (0x200)
    run_op(9'h035, 64'h0000_0000_FF80_0201, 64'h0000_0000_0200_0003);
    chk("R3 broadcast lane1", out_data, 64'h01FE_0100_0004_0002);

    // R6 widening signed-high with junk in upper lanes
    run_op(9'h038, 64'hAAAA_BBBB_0200_FF00, 64'h7777_8888_0040_0100);
    chk("R6 widening", out_data, 64'h0000_0180_FFFF_FF00);
    run_op(9'h038, 64'h5555_0123_0200_FF00, 64'h0001_FFFF_0040_0100);
    chk("R6 upper lanes ignored", out_data, 64'h0000_0180_FFFF_FF00);

    // R8: idle with changing inputs holds the data
    held = out_data;
    in_mode = 9'h031; in_a = '1; in_b = 64'h7FFF_7FFF_7FFF_7FFF;
    @(negedge clk);
    chk("R8 hold data", out_data, held);
    chk("R7 idle valid low", {63'h0, out_valid}, 64'h0);

    // R9: unknown mode
    run_op(9'h034, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    chk("R9 bad mode data", out_data, 64'h0);
    chk("R9 bad mode flag", {63'h0, out_illegal}, 64'h1);
    run_op(9'h037, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0100);
    chk("R9 flag clears", {63'h0, out_illegal}, 64'h0);
    chk("R5 unsigned low byte", out_data, 64'h0000_0000_0000_0001);

    // R11: zero multiplicand under a signed mode
    run_op(9'h036, 64'h8080_8080_8080_8080, 64'h0);
    chk("R11 zero B", out_data, 64'h0);
    // R4 signed high byte: 0x0100 * (-1) -> 0xFFFF
    run_op(9'h036, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_0100);
    chk("R4 signed high byte", out_data, 64'h0000_0000_0000_FFFF);

    done = 1'b1;
    summary();
  end

endmodule